// File: doc/BRIEF.md
# Interrupt Controller with System Registers

This block is the processor-side half of interrupt handling. It watches a small set of device request lines, ranks them by a fixed priority into a cause number, and decides in each cycle whether the pipeline should divert into the interrupt handler. It holds four system registers: a processor control/status word with an enable bit and a saved-enable bit, the handler entry address, the saved return address, and the number of the device that caused the last interrupt.

The pipeline reports whether the current instruction slot holds a real instruction or a bubble, and it supplies the address of the next instruction. System-register read and write instructions reach the block through a combinational read port and a clocked write port. A single strobe marks a return from interrupt. The block answers with a one-cycle taken pulse and a fetch redirect address. On a take the redirect address is the handler address. On a return it is the saved return address.

Top module: `irq_sysreg_ctrl`

## Requirements
- R1: While reset is high, and after it, all four system registers read zero. `irq_taken` and `redirect_valid` stay low during reset.
- R2: System register numbers are: 0 = control/status, 1 = handler address, 2 = return address, 3 = device number. In register 0 only bit 0 (enable) and bit 1 (saved enable) are stored, and every other bit reads 0. Register 3 keeps its low 4 bits and reads zero-extended. The read port is combinational. A write is visible on the read port after the next rising edge.
- R3: Register numbers 4 to 31 always read zero. Writes to them change nothing.
- R4: Request bit 0 (timer) gives cause 1, bit 1 (keys) gives cause 2 and bit 2 (switches) gives cause 3. The lowest cause among the active requests wins, and 0xF means no request. The winning cause is stored in register 3 when an interrupt is taken.
- R5: `irq_taken` is high in the same cycle only when all of these hold: reset is low, the slot is valid, the enable bit is 1, at least one request is active, no return strobe is present, and no write targets register 0.
- R6: In a taken cycle, `redirect_valid` is 1 and `redirect_addr` equals the handler address. At the next edge the return address is loaded with `next_pc`, the device number is loaded with the cause, and {saved enable, enable} is loaded with {enable, 0}.
- R7: A return strobe drives `redirect_valid` high with `redirect_addr` equal to the return address in the same cycle. At the next edge it copies the saved enable into the enable bit and leaves the saved enable unchanged.
- R8: A write to register 0 in a cycle that would otherwise take an interrupt is applied, and no interrupt is taken in that cycle.
- R9: A bubble slot (`slot_valid` low) never takes an interrupt.
- R10: When a write to register 2 or 3 meets a take in the same cycle, the values saved by the take win.
- R11: A return strobe blocks a take in the same cycle. A write to register 0 in the same cycle as a return overrides the enable restore.
- R12: With neither a take nor a return, `redirect_valid` is 0 and `redirect_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dev_req | input | NUM_DEV | Device requests; bit 0 timer, bit 1 keys, bit 2 switches |
| slot_valid | input | 1 | Current slot holds a real instruction |
| next_pc | input | DW | Address of the next instruction, saved on a take |
| sr_rd_idx | input | IDX_W | System register number to read |
| sr_rd_data | output | DW | Contents of the selected system register |
| sr_wr_en | input | 1 | System register write strobe |
| sr_wr_idx | input | IDX_W | System register number to write |
| sr_wr_data | input | DW | Value to write |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_taken | output | 1 | Interrupt taken in this cycle |
| redirect_valid | output | 1 | Fetch must be redirected in this cycle |
| redirect_addr | output | DW | Fetch redirect target |

## Verification
The taken pulse and the redirect outputs depend only on the current inputs and the stored registers, so they are due in the same cycle as the stimulus. The bench samples them 1 ns after driving inputs on the falling edge, well before the next rising edge. Register effects of a take, a return or a write land on the next rising edge. The bench reads them back through the combinational read port at the following falling edge, while all other inputs are idle. The priority table walk re-arms the enable bit before each row, so every row starts from a known control/status value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // system register numbers
   localparam int unsigned SR_CTRL    = 0;
   localparam int unsigned SR_HANDLER = 1;
   localparam int unsigned SR_RETADDR = 2;
   localparam int unsigned SR_CAUSE   = 3;
   localparam int unsigned SR_COUNT   = 4;

   // control/status bit positions
   localparam int unsigned CTRL_EN_BIT    = 0;
   localparam int unsigned CTRL_OLDEN_BIT = 1;

   // system instruction encodings consumed by the decoder
   localparam logic [5:0] OPC_SYSTEM   = 6'o70;
   localparam logic [5:0] SUBOP_RETURN = 6'd1;
   localparam logic [5:0] SUBOP_READ   = 6'd2;
   localparam logic [5:0] SUBOP_WRITE  = 6'd3;

   typedef struct packed {
      logic old_en;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               req_any,
   output logic [CAUSE_W-1:0] cause
);
   localparam logic [CAUSE_W-1:0] IDLE_CAUSE = '1;

   logic [CAUSE_W-1:0] chain [NUM_SRC+1];

   assign chain[NUM_SRC] = IDLE_CAUSE;

   // lower index overrides higher index: source 0 wins
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_stage
      assign chain[g] = req[g] ? CAUSE_W'(g + 1) : chain[g+1];
   end

   assign cause   = chain[0];
   assign req_any = |req;
endmodule

// File: rtl/irqc_take_ctl.sv
module irqc_take_ctl #(
   parameter int unsigned DW = 32
) (
   input  logic          rst,
   input  logic          slot_valid,
   input  logic          en,
   input  logic          req_any,
   input  logic          reti,
   input  logic          ctrl_wr,
   input  logic [DW-1:0] handler_addr,
   input  logic [DW-1:0] ret_addr,
   output logic          take,
   output logic          redir_valid,
   output logic [DW-1:0] redir_addr
);
   logic eligible;

   assign eligible = !rst && slot_valid && en && req_any;
   // software ownership of the control word and a return both defer the take
   assign take     = eligible && !reti && !ctrl_wr;

   always_comb begin
      redir_valid = 1'b0;
      redir_addr  = '0;
      if (take) begin
         redir_valid = 1'b1;
         redir_addr  = handler_addr;
      end else if (reti && !rst) begin
         redir_valid = 1'b1;
         redir_addr  = ret_addr;
      end
   end
endmodule

// File: rtl/irqc_sysregs.sv
module irqc_sysregs
   import irqc_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [DW-1:0]      wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [DW-1:0]      rd_data,
   input  logic               take,
   input  logic               reti,
   input  logic [DW-1:0]      next_pc,
   input  logic [CAUSE_W-1:0] cause,
   output ctrl_t              ctrl,
   output logic [DW-1:0]      handler_addr,
   output logic [DW-1:0]      ret_addr,
   output logic [CAUSE_W-1:0] dev_num
);
   logic [SR_COUNT-1:0] wr_sel;

   for (genvar g = 0; g < SR_COUNT; g++) begin : g_wsel
      assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
   end

   ctrl_t              ctrl_q;
   logic [DW-1:0]      hnd_q;
   logic [DW-1:0]      ret_q;
   logic [CAUSE_W-1:0] num_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (wr_sel[SR_CTRL]) begin
         ctrl_q.en     <= wr_data[CTRL_EN_BIT];
         ctrl_q.old_en <= wr_data[CTRL_OLDEN_BIT];
      end else if (take) begin
         ctrl_q.old_en <= ctrl_q.en;
         ctrl_q.en     <= 1'b0;
      end else if (reti) begin
         ctrl_q.en <= ctrl_q.old_en;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hnd_q <= '0;
      end else if (wr_sel[SR_HANDLER]) begin
         hnd_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ret_q <= '0;
      end else if (take) begin
         ret_q <= next_pc;
      end else if (wr_sel[SR_RETADDR]) begin
         ret_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         num_q <= '0;
      end else if (take) begin
         num_q <= cause;
      end else if (wr_sel[SR_CAUSE]) begin
         num_q <= wr_data[CAUSE_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == IDX_W'(SR_CTRL)) begin
         rd_data = {{(DW-2){1'b0}}, ctrl_q.old_en, ctrl_q.en};
      end else if (rd_idx == IDX_W'(SR_HANDLER)) begin
         rd_data = hnd_q;
      end else if (rd_idx == IDX_W'(SR_RETADDR)) begin
         rd_data = ret_q;
      end else if (rd_idx == IDX_W'(SR_CAUSE)) begin
         rd_data = {{(DW-CAUSE_W){1'b0}}, num_q};
      end
   end

   assign ctrl         = ctrl_q;
   assign handler_addr = hnd_q;
   assign ret_addr     = ret_q;
   assign dev_num      = num_q;
endmodule

// File: rtl/irq_sysreg_ctrl.sv
module irq_sysreg_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter int unsigned NUM_DEV = 3,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_DEV-1:0] dev_req,
   input  logic               slot_valid,
   input  logic [DW-1:0]      next_pc,
   input  logic [IDX_W-1:0]   sr_rd_idx,
   output logic [DW-1:0]      sr_rd_data,
   input  logic               sr_wr_en,
   input  logic [IDX_W-1:0]   sr_wr_idx,
   input  logic [DW-1:0]      sr_wr_data,
   input  logic               reti,
   output logic               irq_taken,
   output logic               redirect_valid,
   output logic [DW-1:0]      redirect_addr
);
   localparam int unsigned MAX_DEV = (1 << CAUSE_W) - 2;

   if (NUM_DEV < 1 || NUM_DEV > MAX_DEV) begin : g_bad_dev
      $error("NUM_DEV must leave the all-ones cause free");
   end
   if (DW < CAUSE_W || DW < 2) begin : g_bad_dw
      $error("DW too narrow for the system registers");
   end
   if ((1 << IDX_W) < SR_COUNT) begin : g_bad_idx
      $error("IDX_W cannot address all system registers");
   end

   logic               req_any;
   logic [CAUSE_W-1:0] cause_w;
   ctrl_t              ctrl_w;
   logic [DW-1:0]      hnd_w;
   logic [DW-1:0]      ret_w;
   logic [CAUSE_W-1:0] num_w;
   logic               ctrl_wr;
   logic               take_w;
   logic               cur_en;
   logic               cur_old_en;

   assign ctrl_wr    = sr_wr_en && (sr_wr_idx == IDX_W'(SR_CTRL));
   assign cur_en     = ctrl_w.en;
   assign cur_old_en = ctrl_w.old_en;

   irqc_prio_enc #(
      .NUM_SRC (NUM_DEV),
      .CAUSE_W (CAUSE_W)
   ) enc_i (
      .req     (dev_req),
      .req_any (req_any),
      .cause   (cause_w)
   );

   irqc_take_ctl #(
      .DW (DW)
   ) take_i (
      .rst          (rst),
      .slot_valid   (slot_valid),
      .en           (cur_en),
      .req_any      (req_any),
      .reti         (reti),
      .ctrl_wr      (ctrl_wr),
      .handler_addr (hnd_w),
      .ret_addr     (ret_w),
      .take         (take_w),
      .redir_valid  (redirect_valid),
      .redir_addr   (redirect_addr)
   );

   irqc_sysregs #(
      .DW      (DW),
      .IDX_W   (IDX_W),
      .CAUSE_W (CAUSE_W)
   ) regs_i (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (sr_wr_en),
      .wr_idx       (sr_wr_idx),
      .wr_data      (sr_wr_data),
      .rd_idx       (sr_rd_idx),
      .rd_data      (sr_rd_data),
      .take         (take_w),
      .reti         (reti),
      .next_pc      (next_pc),
      .cause        (cause_w),
      .ctrl         (ctrl_w),
      .handler_addr (hnd_w),
      .ret_addr     (ret_w),
      .dev_num      (num_w)
   );

   assign irq_taken = take_w;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned DW      = 32,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned CAUSE_W = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               slot_valid,
   input logic               reti,
   input logic               sr_wr_en,
   input logic [IDX_W-1:0]   sr_wr_idx,
   input logic [DW-1:0]      next_pc,
   input logic               irq_taken,
   input logic               redirect_valid,
   input logic [DW-1:0]      redirect_addr,
   input logic               en,
   input logic               old_en,
   input logic [DW-1:0]      hnd,
   input logic [DW-1:0]      ret,
   input logic [CAUSE_W-1:0] num
);
   AST_TAKE_GATED: assert property (@(posedge clk) disable iff (rst)
      irq_taken |-> (en && slot_valid)); // R5
   AST_NO_BUBBLE_TAKE: assert property (@(posedge clk) disable iff (rst)
      !slot_valid |-> !irq_taken); // R9
   AST_TAKE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      irq_taken |-> (redirect_valid && redirect_addr == hnd)); // R6
   AST_TAKE_ENABLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      irq_taken |=> (!en && old_en)); // R6
   AST_TAKE_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
      irq_taken |=> (ret == $past(next_pc))); // R10
   AST_TAKE_CAUSE_VALID: assert property (@(posedge clk) disable iff (rst)
      irq_taken |=> (num != '1)); // R4
   AST_RETURN_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      reti |-> (redirect_valid && redirect_addr == ret && !irq_taken)); // R11
   AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (rst)
      (reti && !(sr_wr_en && sr_wr_idx == '0)) |=> (en == $past(old_en))); // R7
   AST_CTRL_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (sr_wr_en && sr_wr_idx == '0) |-> !irq_taken); // R8
   AST_IDLE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      (!irq_taken && !reti) |-> (!redirect_valid && redirect_addr == '0)); // R12
endmodule

bind irq_sysreg_ctrl irqc_checker #(
   .DW      (DW),
   .IDX_W   (IDX_W),
   .CAUSE_W (CAUSE_W)
) chk_i (
   .clk            (clk),
   .rst            (rst),
   .slot_valid     (slot_valid),
   .reti           (reti),
   .sr_wr_en       (sr_wr_en),
   .sr_wr_idx      (sr_wr_idx),
   .next_pc        (next_pc),
   .irq_taken      (irq_taken),
   .redirect_valid (redirect_valid),
   .redirect_addr  (redirect_addr),
   .en             (cur_en),
   .old_en         (cur_old_en),
   .hnd            (hnd_w),
   .ret            (ret_w),
   .num            (num_w)
);

// File: tb/irq_sysreg_ctrl_tb.sv
module irq_sysreg_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   // packing: [7:4] expected cause, [3] expected take, [2:0] request pattern
   localparam logic [7:0] PRIO_VEC [8] = '{
      8'hF0, 8'h19, 8'h2A, 8'h1B, 8'h3C, 8'h1D, 8'h2E, 8'h1F
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    dev_req = '0;
   logic          slot_valid = 1'b0;
   logic [DW-1:0] next_pc = '0;
   logic [4:0]    sr_rd_idx = '0;
   logic [DW-1:0] sr_rd_data;
   logic          sr_wr_en = 1'b0;
   logic [4:0]    sr_wr_idx = '0;
   logic [DW-1:0] sr_wr_data = '0;
   logic          reti = 1'b0;
   logic          irq_taken;
   logic          redirect_valid;
   logic [DW-1:0] redirect_addr;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_sysreg_ctrl dut_i (
      .clk            (clk),
      .rst            (rst),
      .dev_req        (dev_req),
      .slot_valid     (slot_valid),
      .next_pc        (next_pc),
      .sr_rd_idx      (sr_rd_idx),
      .sr_rd_data     (sr_rd_data),
      .sr_wr_en       (sr_wr_en),
      .sr_wr_idx      (sr_wr_idx),
      .sr_wr_data     (sr_wr_data),
      .reti           (reti),
      .irq_taken      (irq_taken),
      .redirect_valid (redirect_valid),
      .redirect_addr  (redirect_addr)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // read one register at an idle falling edge, then move to the next one
   task automatic chk_reg(input string tag, input logic [4:0] idx, input logic [DW-1:0] exp);
      sr_rd_idx = idx;
      #1;
      chk(tag, sr_rd_data, exp);
      @(negedge clk);
   endtask

   task automatic wsr(input logic [4:0] idx, input logic [DW-1:0] data);
      sr_wr_en   = 1'b1;
      sr_wr_idx  = idx;
      sr_wr_data = data;
      @(negedge clk);
      sr_wr_en   = 1'b0;
   endtask

   task automatic idle();
      dev_req    = '0;
      slot_valid = 1'b0;
      reti       = 1'b0;
      sr_wr_en   = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      dev_req = 3'b111;
      slot_valid = 1'b1;
      #1;
      chk("R1 taken in reset", DW'(irq_taken), 0);
      chk("R1 redirect in reset", DW'(redirect_valid), 0);
      @(negedge clk);
      idle();
      rst = 1'b0;
      chk_reg("R1 ctrl", 0, 0);
      chk_reg("R1 handler", 1, 0);
      chk_reg("R1 retaddr", 2, 0);
      chk_reg("R1 cause", 3, 0);
      #1;
      chk("R12 idle redirect valid", DW'(redirect_valid), 0);
      chk("R12 idle redirect addr", redirect_addr, 0);
      @(negedge clk);

      // R2: layout and write visibility
      wsr(1, 32'h0000_1000);
      chk_reg("R2 handler", 1, 32'h0000_1000);
      wsr(0, 32'hFFFF_FFFF);
      chk_reg("R2 ctrl two bits", 0, 32'h3);
      wsr(0, 0);
      wsr(2, 32'h1234_5678);
      chk_reg("R2 retaddr", 2, 32'h1234_5678);
      wsr(3, 32'hFFFF_FFF5);
      chk_reg("R2 cause 4 bits", 3, 32'h5);

      // R3: reserved numbers
      wsr(4, 32'hDEAD_BEEF);
      wsr(31, 32'hFFFF_FFFF);
      chk_reg("R3 read 4", 4, 0);
      chk_reg("R3 read 31", 31, 0);
      chk_reg("R3 handler kept", 1, 32'h0000_1000);
      chk_reg("R3 ctrl kept", 0, 0);

      // R4/R5/R6: priority table walk
      for (int i = 0; i < 8; i++) begin
         logic [DW-1:0] pc;
         logic          et;
         et = PRIO_VEC[i][3];
         pc = 32'h200 + DW'(i * 4);
         wsr(0, 1);
         dev_req    = PRIO_VEC[i][2:0];
         slot_valid = 1'b1;
         next_pc    = pc;
         #1;
         chk("R5 take", DW'(irq_taken), DW'(et));
         chk("R6 redirect valid", DW'(redirect_valid), DW'(et));
         chk("R6 redirect addr", redirect_addr, et ? 32'h0000_1000 : 32'h0);
         @(negedge clk);
         idle();
         chk_reg("R6 ctrl after", 0, et ? 32'h2 : 32'h1);
         if (et) begin
            chk_reg("R4 cause", 3, DW'(PRIO_VEC[i][7:4]));
            chk_reg("R6 retaddr", 2, pc);
         end
      end

      // R5: enable low
      wsr(0, 0);
      dev_req = 3'b111;
      slot_valid = 1'b1;
      #1;
      chk("R5 disabled", DW'(irq_taken), 0);
      @(negedge clk);
      idle();

      // R9: bubble slot
      wsr(0, 1);
      dev_req = 3'b001;
      slot_valid = 1'b0;
      #1;
      chk("R9 bubble", DW'(irq_taken), 0);
      @(negedge clk);
      idle();
      chk_reg("R9 ctrl kept", 0, 1);

      // R8: control write against a take
      dev_req = 3'b001;
      slot_valid = 1'b1;
      sr_wr_en = 1'b1;
      sr_wr_idx = 0;
      sr_wr_data = 0;
      #1;
      chk("R8 blocked clear", DW'(irq_taken), 0);
      @(negedge clk);
      idle();
      chk_reg("R8 write applied 0", 0, 0);
      wsr(0, 1);
      dev_req = 3'b001;
      slot_valid = 1'b1;
      sr_wr_en = 1'b1;
      sr_wr_idx = 0;
      sr_wr_data = 3;
      #1;
      chk("R8 blocked set", DW'(irq_taken), 0);
      @(negedge clk);
      idle();
      chk_reg("R8 write applied 3", 0, 3);

      // R10: retaddr write loses to take
      dev_req = 3'b100;
      slot_valid = 1'b1;
      next_pc = 32'h300;
      sr_wr_en = 1'b1;
      sr_wr_idx = 2;
      sr_wr_data = 32'hABCD;
      #1;
      chk("R10 take", DW'(irq_taken), 1);
      @(negedge clk);
      idle();
      chk_reg("R10 retaddr", 2, 32'h300);
      chk_reg("R6 nested ctrl", 0, 2);
      chk_reg("R10 cause", 3, 3);

      // R7: return
      reti = 1'b1;
      #1;
      chk("R7 redirect valid", DW'(redirect_valid), 1);
      chk("R7 redirect addr", redirect_addr, 32'h300);
      chk("R7 no take", DW'(irq_taken), 0);
      @(negedge clk);
      idle();
      chk_reg("R7 restore", 0, 3);

      // R11: return blocks take, control write beats restore
      reti = 1'b1;
      dev_req = 3'b001;
      slot_valid = 1'b1;
      #1;
      chk("R11 take blocked", DW'(irq_taken), 0);
      chk("R11 return target", redirect_addr, 32'h300);
      @(negedge clk);
      idle();
      chk_reg("R11 ctrl", 0, 3);
      reti = 1'b1;
      sr_wr_en = 1'b1;
      sr_wr_idx = 0;
      sr_wr_data = 0;
      @(negedge clk);
      idle();
      chk_reg("R11 write wins", 0, 0);

      // R10: cause write loses to take
      wsr(0, 1);
      dev_req = 3'b010;
      slot_valid = 1'b1;
      sr_wr_en = 1'b1;
      sr_wr_idx = 3;
      sr_wr_data = 9;
      #1;
      chk("R10 take 2", DW'(irq_taken), 1);
      @(negedge clk);
      idle();
      chk_reg("R10 cause kept", 3, 2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule